// File: doc/BRIEF.md
# Machine Interrupt Control and Trap Cause Unit

This unit keeps the machine-mode interrupt state of a small RISC-V core that runs only in machine and user mode. It offers four registers on a simple CSR port: an interrupt enable register, an interrupt pending register, a trap cause register and a read-only hart identity register. Besides the three standard machine interrupts (software, timer, external), it carries three local interrupts: a correctable-error interrupt and two internal-timer interrupts.

The unit takes level inputs from each interrupt source. A global machine interrupt enable gates them, and the unit produces a trap request with a matching cause code. A non-maskable interrupt request, with a selector that names its reason, always raises a trap. When the core commits to a trap, it pulses a take strobe. The cause register then records the NMI, interrupt or exception that was taken. CSR reads are combinational. CSR writes and trap records land at the next clock edge.

Top module: `mirq_csr_unit`

## Requirements
- R1: After reset, the enable register (0x304) and the cause register (0x342) both read 0x0000_0000.
- R2: A write to 0x304 keeps only bits 30, 29, 28, 11, 7 and 3 of the write data. Writing all ones reads back 0x7000_0888.
- R3: A read of 0x344 returns the live sources at fixed bits: correctable error 30, internal timer 0 at 29, internal timer 1 at 28, external 11, timer 7, software 3. All other bits read 0, and writes to 0x344 change nothing.
- R4: A read of 0xF14 returns the 28-bit core ID input in bits 31:4 and zero in bits 3:0. Writes to 0xF14 have no effect.
- R5: An access with `csr_en` high to any address other than 0x304, 0x344, 0x342 or 0xF14 reads zero and drives `csr_illegal` high in that same cycle. Accesses to the four known addresses keep it low.
- R6: Without an NMI, `trap_req` is high only when some source is pending, its enable bit is set and `mie_global` is high.
- R7: When several enabled interrupts are pending, `trap_cause` is bit 31 set plus the code of the highest-priority one. The order is external (11), correctable error (30), software (3), timer (7), internal timer 0 (29), internal timer 1 (28).
- R8: `nmi_req` raises `trap_req` regardless of any enable. `trap_cause` then follows `nmi_sel`: 0 gives 0x0000_0000, 1 gives 0xF000_0000, 2 gives 0xF000_0001, 3 gives 0xF000_1000, 4 gives 0xF000_1001 and 5 gives 0xF000_1002. The values 6 and 7 give 0x0000_0000.
- R9: On a `trap_take` cycle, the cause register loads at that edge. An NMI cause wins over an interrupt cause, and an interrupt cause wins over `exc_valid` with `exc_code`. An exception whose code is not 1–7 or 11 leaves the cause register unchanged.
- R10: A CSR write to 0x342 is accepted only for a legal cause value. Legal values are the interrupt causes of R7, the NMI causes of R8, and exception codes 1–7 and 11 with bit 31 clear. Any other value leaves the register unchanged.
- R11: When `trap_take` loads the cause register, a CSR write to 0x342 in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | Write qualifier for the access |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, combinational |
| csr_illegal | output | 1 | Access to an unimplemented address |
| mie_global | input | 1 | Global machine interrupt enable |
| src_sw | input | 1 | Software interrupt level |
| src_tmr | input | 1 | Timer interrupt level |
| src_ext | input | 1 | External interrupt level |
| src_ce | input | 1 | Correctable-error local interrupt level |
| src_it0 | input | 1 | Internal timer 0 local interrupt level |
| src_it1 | input | 1 | Internal timer 1 local interrupt level |
| nmi_req | input | 1 | Non-maskable interrupt request |
| nmi_sel | input | 3 | NMI reason selector |
| exc_valid | input | 1 | Synchronous exception present |
| exc_code | input | 4 | Exception code |
| trap_take | input | 1 | Core commits to the trap this cycle |
| core_id | input | 28 | Hardwired core identity |
| trap_req | output | 1 | Trap request |
| trap_cause | output | 32 | Cause of the requested trap |

## Verification
Four results are combinational and are due in the cycle of the stimulus: read data, the illegal-access flag, the trap request and the selected cause. The bench sets inputs on the falling edge and samples these one time unit later, before any rising edge. Enable writes, cause writes and take-strobe records appear one rising edge after the strobe cycle. The bench therefore drops the strobe at the following falling edge and reads the register back in a separate access. After reset is released, the internal synchronizer holds the unit for two more edges, so checks begin only after four idle cycles.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned CSR_AW    = 12;
  localparam int unsigned NSRC      = 6;

  localparam logic [CSR_AW-1:0] A_ENABLE  = 12'h304;
  localparam logic [CSR_AW-1:0] A_CAUSE   = 12'h342;
  localparam logic [CSR_AW-1:0] A_PENDING = 12'h344;
  localparam logic [CSR_AW-1:0] A_HARTID  = 12'hF14;

  // interrupt bit positions (shared by enable, pending and cause codes)
  localparam int unsigned B_SW  = 3;
  localparam int unsigned B_TMR = 7;
  localparam int unsigned B_EXT = 11;
  localparam int unsigned B_IT1 = 28;
  localparam int unsigned B_IT0 = 29;
  localparam int unsigned B_CE  = 30;

  localparam logic [XLEN-1:0] IRQ_MASK =
    (XLEN'(1) << B_SW) | (XLEN'(1) << B_TMR) | (XLEN'(1) << B_EXT) |
    (XLEN'(1) << B_IT1) | (XLEN'(1) << B_IT0) | (XLEN'(1) << B_CE);

  typedef enum logic [2:0] {
    NMI_PIN      = 3'd0,
    NMI_ST_ERR   = 3'd1,
    NMI_LD_ERR   = 3'd2,
    NMI_FI_ECC   = 3'd3,
    NMI_FI_RGN   = 3'd4,
    NMI_FI_NLOC  = 3'd5
  } nmi_kind_e;

  function automatic logic [XLEN-1:0] nmi_cause(input logic [2:0] sel);
    logic [XLEN-1:0] v;
    case (sel)
      NMI_ST_ERR:  v = 32'hF000_0000;
      NMI_LD_ERR:  v = 32'hF000_0001;
      NMI_FI_ECC:  v = 32'hF000_1000;
      NMI_FI_RGN:  v = 32'hF000_1001;
      NMI_FI_NLOC: v = 32'hF000_1002;
      default:     v = 32'h0000_0000;
    endcase
    return v;
  endfunction

  function automatic logic exc_legal(input logic [3:0] code);
    return ((code >= 4'd1) && (code <= 4'd7)) || (code == 4'd11);
  endfunction

  function automatic logic cause_legal(input logic [XLEN-1:0] v);
    logic ok;
    case (v)
      32'h8000_0003, 32'h8000_0007, 32'h8000_000B,
      32'h8000_001C, 32'h8000_001D, 32'h8000_001E,
      32'h0000_0000, 32'hF000_0000, 32'hF000_0001,
      32'hF000_1000, 32'hF000_1001, 32'hF000_1002: ok = 1'b1;
      default: ok = (v[XLEN-1:4] == '0) && exc_legal(v[3:0]);
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/mirq_rst_sync.sv
module mirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/mirq_en_reg.sv
module mirq_en_reg
  import mirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] en_q
);
  logic [XLEN-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wdata & IRQ_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end
endmodule

// File: rtl/mirq_prio.sv
module mirq_prio
  import mirq_pkg::*;
(
  input  logic [NSRC-1:0] req,   // index 0 = highest priority
  output logic            any,
  output logic [4:0]      code
);
  localparam logic [4:0] RANK_CODE [NSRC] = '{
    5'(B_EXT), 5'(B_CE), 5'(B_SW), 5'(B_TMR), 5'(B_IT0), 5'(B_IT1)
  };

  always_comb begin
    code = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) code = RANK_CODE[i];
    end
    any = |req;
  end
endmodule

// File: rtl/mirq_cause_reg.sv
module mirq_cause_reg
  import mirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_ld,
  input  logic [XLEN-1:0] take_val,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] cause_q
);
  logic            cause_ce;
  logic [XLEN-1:0] cause_d;

  always_comb begin
    cause_ce = 1'b0;
    cause_d  = cause_q;
    if (take_ld) begin
      cause_ce = 1'b1;
      cause_d  = take_val;
    end else if (wr_en && cause_legal(wdata)) begin
      cause_ce = 1'b1;
      cause_d  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_ce) cause_q <= cause_d;
  end
endmodule

// File: rtl/mirq_csr_unit.sv
module mirq_csr_unit
  import mirq_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  input  logic              mie_global,
  input  logic              src_sw,
  input  logic              src_tmr,
  input  logic              src_ext,
  input  logic              src_ce,
  input  logic              src_it0,
  input  logic              src_it1,
  input  logic              nmi_req,
  input  logic [2:0]        nmi_sel,
  input  logic              exc_valid,
  input  logic [3:0]        exc_code,
  input  logic              trap_take,
  input  logic [XLEN-5:0]   core_id,
  output logic              trap_req,
  output logic [XLEN-1:0]   trap_cause
);
  logic            rst_sn;
  logic [XLEN-1:0] en_q;
  logic [XLEN-1:0] pend;
  logic [XLEN-1:0] live;
  logic [NSRC-1:0] ranked;
  logic            irq_any;
  logic [4:0]      irq_code;
  logic [XLEN-1:0] cause_q;
  logic            take_ld;
  logic            wr_en_en;
  logic            wr_en_cause;

  mirq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_sn)
  );

  always_comb begin
    pend        = '0;
    pend[B_SW]  = src_sw;
    pend[B_TMR] = src_tmr;
    pend[B_EXT] = src_ext;
    pend[B_IT1] = src_it1;
    pend[B_IT0] = src_it0;
    pend[B_CE]  = src_ce;
    live        = mie_global ? (pend & en_q) : '0;
    ranked      = {live[B_IT1], live[B_IT0], live[B_TMR],
                   live[B_SW], live[B_CE], live[B_EXT]};
  end

  mirq_prio u_prio (.req(ranked), .any(irq_any), .code(irq_code));

  always_comb begin
    trap_req   = nmi_req | irq_any;
    trap_cause = {28'd0, exc_code};
    if (nmi_req)      trap_cause = nmi_cause(nmi_sel);
    else if (irq_any) trap_cause = {1'b1, 26'd0, irq_code};
    take_ld    = trap_take && (nmi_req || irq_any || (exc_valid && exc_legal(exc_code)));
  end

  always_comb begin
    wr_en_en    = csr_en && csr_we && (csr_addr == A_ENABLE);
    wr_en_cause = csr_en && csr_we && (csr_addr == A_CAUSE);
  end

  mirq_en_reg u_en (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en_en), .wdata(csr_wdata), .en_q(en_q)
  );

  mirq_cause_reg u_cause (
    .clk(clk), .rst_n(rst_sn), .take_ld(take_ld), .take_val(trap_cause),
    .wr_en(wr_en_cause), .wdata(csr_wdata), .cause_q(cause_q)
  );

  always_comb begin
    csr_rdata   = '0;
    csr_illegal = 1'b0;
    case (csr_addr)
      A_ENABLE:  csr_rdata = en_q;
      A_PENDING: csr_rdata = pend;
      A_CAUSE:   csr_rdata = cause_q;
      A_HARTID:  csr_rdata = {core_id, 4'h0};
      default:   csr_illegal = csr_en;
    endcase
  end
endmodule

// File: rtl/mirq_csr_chk.sv
module mirq_csr_chk
  import mirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              csr_en,
  input logic              csr_we,
  input logic [CSR_AW-1:0] csr_addr,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              csr_illegal,
  input logic              mie_global,
  input logic              nmi_req,
  input logic              trap_take,
  input logic [XLEN-5:0]   core_id,
  input logic              trap_req,
  input logic [XLEN-1:0]   trap_cause,
  input logic [XLEN-1:0]   cause_q
);
  a_r2_enable_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_ENABLE) |-> ((csr_rdata & ~IRQ_MASK) == '0));

  a_r4_hartid: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_HARTID) |-> (csr_rdata == {core_id, 4'h0}));

  a_r5_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));

  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_req && !mie_global) |-> !trap_req);

  a_r7_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !nmi_req) |-> trap_cause[XLEN-1]);

  a_r8_nmi_req: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> trap_req);

  a_r9_take_records: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && trap_req) |=> (cause_q == $past(trap_cause)));

  a_r10_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && !(csr_en && csr_we && csr_addr == A_CAUSE)) |=> $stable(cause_q));
endmodule

bind mirq_csr_unit mirq_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
  .csr_addr(csr_addr), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
  .mie_global(mie_global), .nmi_req(nmi_req), .trap_take(trap_take),
  .core_id(core_id), .trap_req(trap_req), .trap_cause(trap_cause),
  .cause_q(cause_q)
);

// File: tb/test_mirq_csr_unit.sv
`timescale 1ns/1ps
module test_mirq_csr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_en, csr_we;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata, csr_rdata;
  logic        csr_illegal;
  logic        mie_global;
  logic        src_sw, src_tmr, src_ext, src_ce, src_it0, src_it1;
  logic        nmi_req;
  logic [2:0]  nmi_sel;
  logic        exc_valid;
  logic [3:0]  exc_code;
  logic        trap_take;
  logic [27:0] core_id;
  logic        trap_req;
  logic [31:0] trap_cause;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;   // 125 MHz

  mirq_csr_unit i_mirq_csr_unit (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .mie_global(mie_global),
    .src_sw(src_sw), .src_tmr(src_tmr), .src_ext(src_ext), .src_ce(src_ce),
    .src_it0(src_it0), .src_it1(src_it1), .nmi_req(nmi_req), .nmi_sel(nmi_sel),
    .exc_valid(exc_valid), .exc_code(exc_code), .trap_take(trap_take),
    .core_id(core_id), .trap_req(trap_req), .trap_cause(trap_cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic set_src(input logic [5:0] v); // {it1,it0,tmr,sw,ce,ext}
    {src_it1, src_it0, src_tmr, src_sw, src_ce, src_ext} = v;
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [31:0] d, output logic ill);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b0; csr_addr = a;
    #1;
    d = csr_rdata; ill = csr_illegal;
    @(negedge clk);
    csr_en = 1'b0;
  endtask

  task automatic pulse_take();
    @(negedge clk);
    trap_take = 1'b1;
    @(negedge clk);
    trap_take = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic il;
    csr_read(12'h304, d, il); chk("R1 enable after reset", d, 32'h0);
    csr_read(12'h342, d, il); chk("R1 cause after reset", d, 32'h0);
  endtask

  task automatic t_enable_mask();
    logic [31:0] d; logic il;
    csr_write(12'h304, 32'hFFFF_FFFF);
    csr_read(12'h304, d, il); chk("R2 all-ones masked", d, 32'h7000_0888);
    csr_write(12'h304, 32'h2000_0080);
    csr_read(12'h304, d, il); chk("R2 partial write", d, 32'h2000_0080);
    csr_write(12'h304, 32'h0);
  endtask

  task automatic t_pending();
    logic [31:0] d; logic il;
    csr_write(12'h344, 32'hFFFF_FFFF);
    csr_read(12'h344, d, il); chk("R3 pending write ignored", d, 32'h0);
    set_src(6'b111111);
    csr_read(12'h344, d, il); chk("R3 all sources", d, 32'h7000_0888);
    set_src(6'b010001);   // it0 + ext
    csr_read(12'h344, d, il); chk("R3 it0 and ext", d, 32'h2000_0800);
    set_src(6'b0);
  endtask

  task automatic t_hartid();
    logic [31:0] d; logic il;
    csr_write(12'hF14, 32'h1234_5678);
    csr_read(12'hF14, d, il); chk("R4 hart id", d, 32'hABC_DEF5 << 4);
  endtask

  task automatic t_unknown();
    logic [31:0] d; logic il;
    csr_read(12'h300, d, il);
    chk("R5 unknown data", d, 32'h0); chk("R5 unknown flag", {31'd0, il}, 32'd1);
    csr_read(12'h344, d, il); chk("R5 known no flag", {31'd0, il}, 32'd0);
    csr_read(12'hF14, d, il); chk("R5 hartid no flag", {31'd0, il}, 32'd0);
  endtask

  task automatic t_gating();
    csr_write(12'h304, 32'h0000_0080);
    @(negedge clk); set_src(6'b001000); mie_global = 1'b0; #1;
    chk("R6 global low", {31'd0, trap_req}, 32'd0);
    @(negedge clk); mie_global = 1'b1; #1;
    chk("R6 all set", {31'd0, trap_req}, 32'd1);
    chk("R7 timer cause", trap_cause, 32'h8000_0007);
    @(negedge clk); set_src(6'b000100); #1;
    chk("R6 sw not enabled", {31'd0, trap_req}, 32'd0);
    csr_write(12'h304, 32'h0); set_src(6'b001000); #1;
    chk("R6 enable cleared", {31'd0, trap_req}, 32'd0);
  endtask

  task automatic t_priority();
    logic [31:0] exp [6];
    exp = '{32'h8000_000B, 32'h8000_001E, 32'h8000_0003,
            32'h8000_0007, 32'h8000_001D, 32'h8000_001C};
    csr_write(12'h304, 32'hFFFF_FFFF);
    mie_global = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); set_src(6'b111111 << i); #1;
      chk("R7 priority", trap_cause, exp[i]);
    end
    @(negedge clk); set_src(6'b0);
  endtask

  task automatic t_nmi();
    logic [31:0] exp [8];
    exp = '{32'h0, 32'hF000_0000, 32'hF000_0001, 32'hF000_1000,
            32'hF000_1001, 32'hF000_1002, 32'h0, 32'h0};
    csr_write(12'h304, 32'h0);
    mie_global = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); nmi_req = 1'b1; nmi_sel = 3'(i); #1;
      chk("R8 nmi req", {31'd0, trap_req}, 32'd1);
      chk("R8 nmi cause", trap_cause, exp[i]);
    end
    @(negedge clk); nmi_req = 1'b0;
  endtask

  task automatic t_take();
    logic [31:0] d; logic il;
    csr_write(12'h304, 32'hFFFF_FFFF);
    mie_global = 1'b1;
    @(negedge clk);
    set_src(6'b000001); nmi_req = 1'b1; nmi_sel = 3'd4; exc_valid = 1'b1; exc_code = 4'd2;
    pulse_take();
    csr_read(12'h342, d, il); chk("R9 nmi wins", d, 32'hF000_1001);
    nmi_req = 1'b0;
    pulse_take();
    csr_read(12'h342, d, il); chk("R9 irq beats exception", d, 32'h8000_000B);
    set_src(6'b0); exc_code = 4'd5;
    pulse_take();
    csr_read(12'h342, d, il); chk("R9 exception", d, 32'h0000_0005);
    exc_code = 4'd9;
    pulse_take();
    csr_read(12'h342, d, il); chk("R9 bad exception code held", d, 32'h0000_0005);
    exc_valid = 1'b0;
  endtask

  task automatic t_cause_write();
    logic [31:0] d; logic il;
    csr_write(12'h342, 32'hF000_1002);
    csr_read(12'h342, d, il); chk("R10 legal nmi value", d, 32'hF000_1002);
    csr_write(12'h342, 32'h8000_0005);
    csr_read(12'h342, d, il); chk("R10 illegal value held", d, 32'hF000_1002);
    csr_write(12'h342, 32'h0000_000B);
    csr_read(12'h342, d, il); chk("R10 legal exception", d, 32'h0000_000B);
    csr_write(12'h342, 32'h0000_0008);
    csr_read(12'h342, d, il); chk("R10 code 8 held", d, 32'h0000_000B);
  endtask

  task automatic t_take_vs_write();
    logic [31:0] d; logic il;
    @(negedge clk);
    exc_valid = 1'b1; exc_code = 4'd4; trap_take = 1'b1;
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = 12'h342; csr_wdata = 32'h0000_0002;
    @(negedge clk);
    trap_take = 1'b0; csr_en = 1'b0; csr_we = 1'b0; exc_valid = 1'b0;
    csr_read(12'h342, d, il); chk("R11 take beats write", d, 32'h0000_0004);
  endtask

  initial begin
    #(8 * 50000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; csr_en = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    mie_global = 1'b0; set_src(6'b0); nmi_req = 1'b0; nmi_sel = '0;
    exc_valid = 1'b0; exc_code = '0; trap_take = 1'b0; core_id = 28'hABC_DEF5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable_mask();
    t_pending();
    t_hartid();
    t_unknown();
    t_gating();
    t_priority();
    t_nmi();
    t_take();
    t_cause_write();
    t_take_vs_write();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule